// File: doc/BRIEF.md
# Odd-Ones After Double-Zero Detector

This block watches a serial bit stream, one bit per clock, and raises its flag output while two facts hold together: the number of 1 bits taken in since reset is odd, and somewhere in the stream since reset two 0 bits have arrived back to back. The double-zero memory is sticky. Only reset clears it. The parity keeps toggling on every 1 bit for as long as the block runs.

The block is a Moore machine with six states. The flag is decoded from the registered state alone, so a new input bit can affect the flag only after the next rising clock edge. Each state code carries three fields. Bit 0 holds the ones-parity (1 means odd). Bit 1 marks a single 0 that is waiting for a partner. Bit 2 records that a 00 pair has been seen. The double-zero condition can be met before or after the parity first turns odd, and the state space has a path for each order.

Top module: `odd_after_dz_detector`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, the machine returns to the even-parity, no-pending-zero, no-pair state. `z_out` reads 0 after that edge.
- R2: After every clock edge with `rst_n` high, `z_out` is 1 exactly when the count of 1 bits accepted since reset is odd and a 00 pair has been accepted since reset.
- R3: `z_out` depends only on the registered state. Changing `din` between clock edges leaves `z_out` unchanged until the next rising edge.
- R4: A stream that completes its 00 pair while the parity is even, then receives a 1, drives `z_out` high (for example 0,0,1).
- R5: A stream whose parity turns odd first and then completes a 00 pair drives `z_out` high on the second 0 (for example 1,0,0).
- R6: A 1 bit arriving while a single 0 is pending cancels that pending 0. The sequence 0,1,0,1,... never forms a pair, so `z_out` stays 0.
- R7: Once a pair has been seen, a 0 input keeps `z_out` at its current value and a 1 input inverts it.
- R8: Only reset clears the double-zero memory. Long streams after the first pair keep following the parity alone.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous reset, active low |
| din | input | 1 | Serial data bit, sampled on each rising edge |
| z_out | output | 1 | Detector flag, decoded from state only |

## Verification
The checker assumes that `din` is a clean 0 or 1 at each sampling edge. It also assumes that reset is applied before the first data bit, so the state register never holds one of its two unused codes. The bench drives `din` only at falling edges and starts every sequence with a synchronous reset. This keeps the register inside the six legal codes that the sticky-pair and parity-toggle properties rely on. An exhaustive sweep covers every input sequence up to eight bits, and directed runs extend well past the first pair.

// File: rtl/dz_pkg.sv
// Shared encoding for the double-zero / odd-parity detector.
// Bit 0 = ones-parity (1 = odd), bit 1 = single zero pending,
// bit 2 = a 00 pair has been seen. Pending and seen never coexist.
package dz_pkg;
    localparam int STATE_W  = 3;
    localparam int ODD_BIT  = 0;
    localparam int PEND_BIT = 1;
    localparam int SEEN_BIT = 2;

    typedef enum logic [STATE_W-1:0] {
        ST_EVEN      = 3'b000,
        ST_ODD       = 3'b001,
        ST_EVEN_Z    = 3'b010,
        ST_ODD_Z     = 3'b011,
        ST_EVEN_PAIR = 3'b100,
        ST_ODD_PAIR  = 3'b101
    } dz_state_e;
endpackage

// File: rtl/dz_next_state.sv
// Transition function of the detector.
// Assumes the current state is one of the six legal codes; any other code
// steers back to the reset state so the machine recovers on its own.
module dz_next_state
    import dz_pkg::*;
(
    input  dz_state_e cur_st,
    input  logic      bit_in,
    output dz_state_e nxt_st
);
    // Pick the successor state from the current state and input bit.
    always_comb begin
        case (cur_st)
            ST_EVEN:      nxt_st = bit_in ? ST_ODD       : ST_EVEN_Z;
            ST_ODD:       nxt_st = bit_in ? ST_EVEN      : ST_ODD_Z;
            ST_EVEN_Z:    nxt_st = bit_in ? ST_ODD       : ST_EVEN_PAIR;
            ST_ODD_Z:     nxt_st = bit_in ? ST_EVEN      : ST_ODD_PAIR;
            ST_EVEN_PAIR: nxt_st = bit_in ? ST_ODD_PAIR  : ST_EVEN_PAIR;
            ST_ODD_PAIR:  nxt_st = bit_in ? ST_EVEN_PAIR : ST_ODD_PAIR;
            default:      nxt_st = ST_EVEN;
        endcase
    end
endmodule

// File: rtl/dz_state_reg.sv
// State register with synchronous active-low reset to the even/no-pair state.
// Assumes rst_n is synchronous to clk.
module dz_state_reg
    import dz_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  dz_state_e nxt_st,
    output dz_state_e cur_st
);
    // Hold the machine state; reset wins over the computed successor.
    always_ff @(posedge clk) begin
        if (!rst_n) cur_st <= ST_EVEN;
        else        cur_st <= nxt_st;
    end
endmodule

// File: rtl/dz_out_decode.sv
// Moore output decode: the flag is a function of the state code alone.
// Assumes legal state codes; only the odd-parity, pair-seen state asserts.
module dz_out_decode
    import dz_pkg::*;
(
    input  dz_state_e cur_st,
    output logic      flag
);
    // Raise the flag only in the odd-parity state after a pair.
    always_comb flag = (cur_st == ST_ODD_PAIR);
endmodule

// File: rtl/odd_after_dz_detector.sv
// Top level: serial detector for "odd number of ones and a 00 pair seen".
// Assumes din is synchronous to clk and reset precedes the first data bit.
module odd_after_dz_detector
    import dz_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic z_out
);
    dz_state_e state_q;
    dz_state_e state_d;

    dz_next_state u_next (
        .cur_st (state_q),
        .bit_in (din),
        .nxt_st (state_d)
    );

    dz_state_reg u_reg (
        .clk    (clk),
        .rst_n  (rst_n),
        .nxt_st (state_d),
        .cur_st (state_q)
    );

    dz_out_decode u_dec (
        .cur_st (state_q),
        .flag   (z_out)
    );
endmodule

// File: rtl/dz_checker.sv
// Property checker for odd_after_dz_detector, attached through bind.
// Assumes din is a clean 0 or 1 at each edge and reset precedes data.
module dz_checker
    import dz_pkg::*;
(
    input logic               clk,
    input logic               rst_n,
    input logic               din,
    input logic               z_out,
    input logic [STATE_W-1:0] state_q
);
    // R1
    reset_clears_flag_chk: assert property (@(posedge clk)
        !rst_n |=> !z_out);

    // R7
    one_toggles_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (z_out && din) |=> !z_out);

    // R7
    zero_holds_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (z_out && !din) |=> z_out);

    // R8
    pair_memory_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        state_q[SEEN_BIT] |=> state_q[SEEN_BIT]);

    // R2
    flag_needs_pair_and_odd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        z_out |-> (state_q[SEEN_BIT] && state_q[ODD_BIT]));

    // R6
    pending_and_pair_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(state_q[PEND_BIT] && state_q[SEEN_BIT]));

    // R6
    one_clears_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
        din |=> !state_q[PEND_BIT]);
endmodule

bind odd_after_dz_detector dz_checker u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .din     (din),
    .z_out   (z_out),
    .state_q (state_q)
);

// File: tb/sim_odd_after_dz_detector.sv
`timescale 1ns/1ps
module sim_odd_after_dz_detector;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic din = 1'b0;
    logic z_out;

    int vectors = 0;
    int miscompares = 0;
    bit done = 1'b0;

    // reference model state
    int  ones_cnt;
    bit  prev_zero;
    bit  pair_seen;

    odd_after_dz_detector u0 (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (din),
        .z_out (z_out)
    );

    always #2.5 clk = ~clk;

    function automatic bit model_z();
        return (ones_cnt % 2 == 1) && pair_seen;
    endfunction

    task automatic check(input bit got, input bit exp, input string req);
        vectors++;
        if (got !== exp) begin
            miscompares++;
            $display("FAIL %s: z_out=%0b expected %0b at %0t", req, got, exp, $time);
        end
    endtask

    // Called at a falling edge; returns at the next falling edge.
    task automatic do_reset();
        rst_n = 1'b0;
        @(posedge clk); #1;
        ones_cnt = 0; prev_zero = 1'b0; pair_seen = 1'b0;
        check(z_out, 1'b0, "R1");
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    // Called at a falling edge; returns at the next falling edge.
    task automatic apply(input bit b, input string req);
        din = b;
        #0.5;
        check(z_out, model_z(), "R3");
        if (b) begin
            ones_cnt++;
            prev_zero = 1'b0;
        end else begin
            if (prev_zero) pair_seen = 1'b1;
            prev_zero = 1'b1;
        end
        @(posedge clk); #1;
        check(z_out, model_z(), req);
        @(negedge clk);
    endtask

    initial begin
        @(negedge clk);
        do_reset();

        // R2 exhaustive sweep of all sequences up to eight bits
        for (int len = 1; len <= 8; len++) begin
            for (int pat = 0; pat < (1 << len); pat++) begin
                do_reset();
                for (int i = 0; i < len; i++) apply(pat[i], "R2");
            end
        end

        // R4 pair first, parity odd afterwards
        do_reset();
        apply(1'b0, "R4"); apply(1'b0, "R4"); apply(1'b1, "R4");
        check(z_out, 1'b1, "R4");

        // R5 parity odd first, pair afterwards
        do_reset();
        apply(1'b1, "R5"); apply(1'b0, "R5"); apply(1'b0, "R5");
        check(z_out, 1'b1, "R5");

        // R6 alternating stream never forms a pair
        do_reset();
        for (int i = 0; i < 20; i++) begin
            apply(1'b0, "R6"); apply(1'b1, "R6");
            check(z_out, 1'b0, "R6");
        end

        // R7 zeros hold, ones toggle once the pair is seen
        do_reset();
        apply(1'b0, "R7"); apply(1'b0, "R7");
        for (int i = 0; i < 6; i++) begin
            apply(1'b1, "R7");
            for (int k = 0; k < 3; k++) apply(1'b0, "R7");
        end

        // R8 long pseudo-random run after the pair; only reset clears it
        do_reset();
        apply(1'b0, "R8"); apply(1'b0, "R8");
        begin
            logic [15:0] lfsr = 16'hACE1;
            for (int i = 0; i < 400; i++) begin
                lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
                apply(lfsr[0], "R8");
            end
        end
        do_reset();
        apply(1'b1, "R8");
        check(z_out, 1'b0, "R8");

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            miscompares++;
            $display("FAIL watchdog: run did not complete, got timeout expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end
endmodule